// File: doc/BRIEF.md
# Serial Flash Slave Interface Front-End

This block is the pin-side front end of a small serial flash memory. It watches the four serial pins (clock, active-low select, data in, active-low hold), all of them oversampled by the system clock, and turns the bit stream into whole bytes. The first byte of each selection is taken as the command opcode. Addressed commands are followed by a 24-bit address that arrives most significant byte first. Every received byte goes to a downstream command unit over a valid/ready byte port, with a tag that says whether it is an opcode, an address or a data byte.

For read-type commands the block pulls bytes from the command unit through a second valid/ready port and shifts them out on the serial output, most significant bit first. Output bits change on the falling serial clock edge and input bits are sampled on the rising one, so clock idle-low and clock idle-high operation both work without configuration. Hold freezes a transfer at any bit, and the transfer then resumes with its counters intact. The serial output has a separate enable, which is low whenever the device is deselected, held, or not in a read phase.

Top module: `spi_flash_front`

## Requirements
- R1: After reset, rx_valid, spi_miso_oe, tx_ready and seq_end are all 0.
- R2: While spi_cs_n is high, clock and data activity on the serial pins produces no received byte and spi_miso_oe stays 0.
- R3: The first byte after spi_cs_n falls is built from spi_mosi sampled on rising spi_sck edges, MSB first. It is forwarded with rx_kind 0 (opcode), and cmd_opcode takes its value.
- R4: Opcodes 0x02, 0x03, 0x20 and 0xD8 are followed by three bytes forwarded with rx_kind 1 (address). cmd_addr ends up holding them as first byte in bits 23:16, second in 15:8 and third in 7:0.
- R5: After the opcode, or after the address of an addressed opcode, every further byte of an opcode other than 0x03 or 0x05 is forwarded with rx_kind 2 (data).
- R6: While spi_hold_n is low, spi_sck edges are ignored and spi_miso_oe is 0. After release the transfer continues from the bit where it stopped.
- R7: If spi_cs_n rises in the middle of a byte, that partial byte is not forwarded. Every rise of spi_cs_n after a selection gives a single one-cycle pulse on seq_end.
- R8: Once rx_valid is raised, rx_valid and rx_data stay unchanged until rx_ready is seen high.
- R9: For opcode 0x03 (after its address) and opcode 0x05 (right after the opcode), the bytes taken from tx_data are driven on spi_miso MSB first, changing on falling spi_sck edges, with spi_miso_oe high. tx_ready pulses for one cycle for each byte taken while tx_valid is high. A byte slot that meets tx_valid low sends 0xFF. No incoming byte is forwarded in this phase.
- R10: All of the above hold for a serial clock idling low at selection and for one idling high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least eight times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Active-low device select pin |
| spi_mosi | input | 1 | Serial data into the device |
| spi_hold_n | input | 1 | Active-low hold pin |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |
| rx_valid | output | 1 | A received byte is presented |
| rx_ready | input | 1 | Downstream accepts the presented byte |
| rx_data | output | 8 | Received byte value |
| rx_kind | output | 2 | Byte tag: 0 opcode, 1 address, 2 data |
| cmd_opcode | output | 8 | Opcode of the current command |
| cmd_addr | output | 24 | Address collected for the current command |
| seq_end | output | 1 | One-cycle pulse when the device is deselected |
| tx_data | input | 8 | Next byte to send in a read phase |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_ready | output | 1 | One-cycle pulse: tx_data was taken |

## Verification
The assertions assume that the serial pins change slowly compared to the system clock. Select, hold and clock edges are taken to be several system cycles apart, so a select edge never lands in the same cycle as a clock edge and no two select edges come in consecutive cycles. The bench drives each serial half period as ten system clocks. It changes select and hold only while the serial clock has been stable for a full half period, and it toggles the clock during hold only in pairs, so the clock level on release is the level before the hold. With these spacings a pin change crosses the two-stage synchronizer long before the next edge of the same pin.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;

    typedef enum logic [1:0] {
        PH_OPC   = 2'd0,
        PH_ADDR  = 2'd1,
        PH_WDATA = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        KIND_OPC  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [BYTE_W-1:0]   data;
    } rx_byte_t;

    function automatic logic op_has_addr(input logic [BYTE_W-1:0] op);
        case (op)
            8'h02, 8'h03, 8'h20, 8'hD8: op_has_addr = 1'b1;
            default:                    op_has_addr = 1'b0;
        endcase
    endfunction

    function automatic logic op_is_read(input logic [BYTE_W-1:0] op);
        case (op)
            8'h03, 8'h05: op_is_read = 1'b1;
            default:      op_is_read = 1'b0;
        endcase
    endfunction

    function automatic kind_e kind_of(input phase_e ph);
        case (ph)
            PH_OPC:  kind_of = KIND_OPC;
            PH_ADDR: kind_of = KIND_ADDR;
            default: kind_of = KIND_DATA;
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int           N       = 4,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] q_dly
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {(STAGES+1){RST_VAL[g]}};
            else     pipe <= {pipe[STAGES-1:0], d[g]};
        end
        assign q[g]     = pipe[STAGES-1];
        assign q_dly[g] = pipe[STAGES];
    end

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
    import spi_fe_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = ADDR_W,
    parameter int NA = ADDR_BYTES,
    localparam int BW = $clog2(DW),
    localparam int CW = $clog2(NA + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          sel,
    input  logic          held,
    input  logic          sck_rise,
    input  logic          mosi,
    input  logic          rx_ready,
    output logic          rx_valid,
    output rx_byte_t      rx_byte,
    output logic [DW-1:0] cmd_opcode,
    output logic [AW-1:0] cmd_addr,
    output logic          seq_end,
    output phase_e        phase,
    output logic [BW-1:0] bit_cnt
);

    localparam logic [BW-1:0] BIT_LAST  = BW'(DW - 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(NA - 1);

    logic [DW-1:0] shift;
    logic [CW-1:0] addr_cnt;
    logic [DW-1:0] nxt_byte;
    logic          advance;
    logic          byte_done;

    assign advance   = sel && !held && sck_rise && !start;
    assign nxt_byte  = {shift[DW-2:0], mosi};
    assign byte_done = advance && (bit_cnt == BIT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift      <= '0;
            bit_cnt    <= '0;
            addr_cnt   <= '0;
            phase      <= PH_OPC;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
            seq_end    <= 1'b0;
        end else begin
            seq_end <= stop;
            if (start) begin
                bit_cnt  <= '0;
                addr_cnt <= '0;
                phase    <= PH_OPC;
            end else if (advance) begin
                bit_cnt <= bit_cnt + 1'b1;
                shift   <= nxt_byte;
                if (byte_done) begin
                    case (phase)
                        PH_OPC: begin
                            cmd_opcode <= nxt_byte;
                            addr_cnt   <= '0;
                            if (op_has_addr(nxt_byte))     phase <= PH_ADDR;
                            else if (op_is_read(nxt_byte)) phase <= PH_READ;
                            else                           phase <= PH_WDATA;
                        end
                        PH_ADDR: begin
                            cmd_addr <= {cmd_addr[AW-DW-1:0], nxt_byte};
                            addr_cnt <= addr_cnt + 1'b1;
                            if (addr_cnt == ADDR_LAST)
                                phase <= op_is_read(cmd_opcode) ? PH_READ : PH_WDATA;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else if (byte_done && phase != PH_READ) begin
            rx_valid     <= 1'b1;
            rx_byte.kind <= kind_of(phase);
            rx_byte.data <= nxt_byte;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        held && !start |=> $stable(bit_cnt) && $stable(phase));               // R6
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel && !start |=> $stable(bit_cnt));                                  // R2
    AST_RX_KEEP: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready && !byte_done |=> rx_valid && $stable(rx_byte)); // R8
    AST_SEQ_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        seq_end |=> !seq_end);                                                 // R7

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
    import spi_fe_pkg::*;
#(
    parameter int DW = BYTE_W,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sel,
    input  logic          held,
    input  logic          sck_fall,
    input  phase_e        phase,
    input  logic [BW-1:0] bit_cnt,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic          miso,
    output logic          miso_oe
);

    logic [DW-1:0] sh;
    logic          active;
    logic          step;

    assign step = sel && !held && sck_fall && !start && (phase == PH_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            active   <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            tx_ready <= 1'b0;
            if (start) begin
                active <= 1'b0;
                sh     <= '0;
            end else if (step) begin
                if (bit_cnt == '0) begin
                    sh       <= tx_valid ? tx_data : '1;
                    active   <= 1'b1;
                    tx_ready <= tx_valid;
                end else begin
                    sh <= {sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    assign miso    = sh[DW-1];
    assign miso_oe = sel && !held && active;

    AST_TX_POP_READ: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> $past(phase) == PH_READ);   // R9
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> phase == PH_READ);           // R9

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic [1:0]        rx_kind,
    output logic [BYTE_W-1:0] cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              seq_end,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    localparam int BW = $clog2(BYTE_W);
    localparam int I_SCK = 0, I_MOSI = 1, I_CS = 2, I_HOLD = 3;

    logic [3:0] pins, pin_q, pin_d;
    logic       sck_rise, sck_fall, cs_fall, cs_rise, sel, held;
    rx_byte_t   rx_byte;
    phase_e     phase;
    logic [BW-1:0] bit_cnt;

    assign pins = {spi_hold_n, spi_cs_n, spi_mosi, spi_sck};

    spi_fe_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk(clk), .rst(rst), .d(pins), .q(pin_q), .q_dly(pin_d)
    );

    assign sck_rise = pin_q[I_SCK] && !pin_d[I_SCK];
    assign sck_fall = !pin_q[I_SCK] && pin_d[I_SCK];
    assign cs_fall  = !pin_q[I_CS] && pin_d[I_CS];
    assign cs_rise  = pin_q[I_CS] && !pin_d[I_CS];
    assign sel      = !pin_q[I_CS];
    assign held     = !pin_q[I_HOLD];

    spi_fe_rx u_rx (
        .clk(clk), .rst(rst), .start(cs_fall), .stop(cs_rise), .sel(sel),
        .held(held), .sck_rise(sck_rise), .mosi(pin_q[I_MOSI]),
        .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .seq_end(seq_end),
        .phase(phase), .bit_cnt(bit_cnt)
    );

    spi_fe_tx u_tx (
        .clk(clk), .rst(rst), .start(cs_fall), .sel(sel), .held(held),
        .sck_fall(sck_fall), .phase(phase), .bit_cnt(bit_cnt),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    assign rx_data = rx_byte.data;
    assign rx_kind = rx_byte.kind;

endmodule

// File: tb/spi_flash_front_tb.sv
`timescale 1ns/1ps
module spi_flash_front_tb;

    localparam time H = 40ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
    logic miso, miso_oe, rx_valid, seq_end, tx_ready;
    logic rx_ready = 1'b1;
    logic tx_valid = 1'b1;
    logic [7:0] rx_data, cmd_opcode, tx_data;
    logic [1:0] rx_kind;
    logic [23:0] cmd_addr;

    always #2ns clk = ~clk;

    spi_flash_front u_dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_kind(rx_kind), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
        .seq_end(seq_end), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready)
    );

    int nchk = 0, nerr = 0;
    int rx_cnt = 0, seq_cnt = 0, tx_idx = 0;
    logic [7:0] rxq_d [64];
    logic [1:0] rxq_k [64];
    logic mode3 = 1'b0;
    logic oe_all;

    function automatic logic [7:0] tx_val(input int i);
        return 8'(i * 29 + 8'h5A);
    endfunction
    assign tx_data = tx_val(tx_idx);

    always @(posedge clk) begin
        if (!rst && rx_valid && rx_ready) begin
            rxq_d[rx_cnt[5:0]] <= rx_data;
            rxq_k[rx_cnt[5:0]] <= rx_kind;
            rx_cnt <= rx_cnt + 1;
        end
        if (!rst && seq_end) seq_cnt <= seq_cnt + 1;
        if (!rst && tx_ready) tx_idx <= tx_idx + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic got);
        sck = 1'b0; mosi = b;
        #H;
        got = miso; oe_all &= miso_oe;
        sck = 1'b1;
        #H;
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] g);
        for (int i = 7; i >= 0; i--) sbit(b[i], g[i]);
    endtask

    task automatic sel_begin(input logic m3);
        mode3 = m3; sck = m3;
        #(2*H);
        cs_n = 1'b0;
        #H;
    endtask

    task automatic sel_end();
        if (!mode3) sck = 1'b0;
        #H;
        cs_n = 1'b1;
        #(2*H);
    endtask

    task automatic check_rx(input int idx, input logic [1:0] k, input logic [7:0] d, input string req);
        chk(rxq_k[idx[5:0]] == k && rxq_d[idx[5:0]] == d, req,
            {rxq_k[idx[5:0]], rxq_d[idx[5:0]]}, {k, d});
    endtask

    initial begin
        #(640us);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] g;
        logic b;
        int base, sbase, t0;
        repeat (5) @(posedge clk);
        #1ns;
        chk(rx_valid == 0 && miso_oe == 0 && tx_ready == 0 && seq_end == 0, "R1",
            {rx_valid, miso_oe, tx_ready, seq_end}, 0);
        rst = 1'b0;
        #(4*H);

        // R2: activity while deselected
        base = rx_cnt; oe_all = 1'b1;
        for (int i = 0; i < 24; i++) sbit(i[0] ^ i[2], b);
        sck = 1'b0; #(2*H);
        chk(rx_cnt == base, "R2 bytes", rx_cnt - base, 0);
        chk(oe_all == 1'b0 && miso_oe == 1'b0, "R2 oe", miso_oe, 0);

        // R3 / R10: sweep every opcode, alternating clock idle level
        for (int op = 0; op < 256; op++) begin
            base = rx_cnt; sbase = seq_cnt;
            sel_begin(op[0]);
            sbyte(8'(op), g);
            sel_end();
            chk(rx_cnt == base + 1 && rxq_d[base[5:0]] == 8'(op) && rxq_k[base[5:0]] == 2'd0
                && cmd_opcode == 8'(op), op[0] ? "R3 R10 mode3" : "R3 R10 mode0",
                {rxq_k[base[5:0]], rxq_d[base[5:0]]}, op);
            chk(seq_cnt == sbase + 1, "R7 seq_end", seq_cnt - sbase, 1);
        end

        // R4 / R5: addressed write in both modes
        for (int m = 0; m < 2; m++) begin
            base = rx_cnt;
            sel_begin(m[0]);
            sbyte(8'h02, g); sbyte(8'h12, g); sbyte(8'h34, g); sbyte(8'h56 + 8'(m), g);
            sbyte(8'hC3, g); sbyte(8'h00, g); sbyte(8'hFF, g);
            sel_end();
            chk(rx_cnt == base + 7, "R4 count", rx_cnt - base, 7);
            check_rx(base + 1, 2'd1, 8'h12, "R4 addr0");
            check_rx(base + 3, 2'd1, 8'h56 + 8'(m), "R4 addr2");
            chk(cmd_addr == 24'h123456 + 24'(m), "R4 cmd_addr", cmd_addr, 24'h123456 + m);
            check_rx(base + 4, 2'd2, 8'hC3, "R5 data0");
            check_rx(base + 6, 2'd2, 8'hFF, "R5 data2");
        end

        // R5: non-addressed opcode followed by data
        base = rx_cnt;
        sel_begin(1'b0);
        sbyte(8'h01, g); sbyte(8'h9C, g);
        sel_end();
        check_rx(base + 1, 2'd2, 8'h9C, "R5 no-addr data");

        // R9 / R10: addressed read in both modes
        for (int m = 0; m < 2; m++) begin
            base = rx_cnt;
            sel_begin(m[0]);
            sbyte(8'h03, g); sbyte(8'h00, g); sbyte(8'h01, g); sbyte(8'h02, g);
            t0 = tx_idx; oe_all = 1'b1;
            for (int k = 0; k < 4; k++) begin
                sbyte(8'hA5, g);
                chk(g == tx_val(t0 + k), m ? "R9 R10 read mode3" : "R9 R10 read mode0", g, tx_val(t0 + k));
            end
            chk(oe_all == 1'b1, "R9 oe", oe_all, 1);
            sel_end();
            chk(rx_cnt == base + 4, "R9 no forward", rx_cnt - base, 4);
            chk(miso_oe == 1'b0, "R2 oe after deselect", miso_oe, 0);
        end

        // R9: immediate read opcode and empty source
        sel_begin(1'b1);
        sbyte(8'h05, g);
        t0 = tx_idx;
        sbyte(8'h00, g);
        chk(g == tx_val(t0), "R9 status-style read", g, tx_val(t0));
        tx_valid = 1'b0;
        t0 = tx_idx;
        sbyte(8'h00, g);
        chk(g == 8'hFF, "R9 empty byte", g, 8'hFF);
        sbyte(8'h00, g);
        chk(tx_idx == t0, "R9 no pop when empty", tx_idx - t0, 0);
        sel_end();
        tx_valid = 1'b1;

        // R6: hold in the middle of a data byte
        base = rx_cnt;
        sel_begin(1'b0);
        sbyte(8'h06, g);
        for (int i = 7; i >= 4; i--) sbit(b, b);
        hold_n = 1'b0; #(2*H);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; mosi = 1'b1; #H; sck = 1'b1; #H;
        end
        chk(rx_cnt == base + 1, "R6 frozen", rx_cnt - base, 1);
        hold_n = 1'b1; #(2*H);
        for (int i = 3; i >= 0; i--) sbit(1'b0, b);
        sel_end();
        chk(rx_cnt == base + 2, "R6 resumed count", rx_cnt - base, 2);
        check_rx(base + 1, 2'd2, 8'h00, "R6 resumed byte");

        // R6: hold during a read
        sel_begin(1'b0);
        sbyte(8'h05, g);
        t0 = tx_idx;
        for (int i = 7; i >= 4; i--) sbit(1'b0, g[i]);
        hold_n = 1'b0; #(2*H);
        chk(miso_oe == 1'b0, "R6 oe held", miso_oe, 0);
        sck = 1'b0; #H; sck = 1'b1; #H;
        hold_n = 1'b1; #(2*H);
        chk(miso_oe == 1'b1, "R6 oe resumed", miso_oe, 1);
        for (int i = 3; i >= 0; i--) sbit(1'b0, g[i]);
        chk(g == tx_val(t0), "R6 read across hold", g, tx_val(t0));
        sel_end();

        // R7: abort mid-byte
        base = rx_cnt; sbase = seq_cnt;
        sel_begin(1'b1);
        sbyte(8'h01, g);
        for (int i = 0; i < 5; i++) sbit(1'b1, b);
        sel_end();
        #(4*H);
        chk(rx_cnt == base + 1, "R7 partial dropped", rx_cnt - base, 1);
        chk(seq_cnt == sbase + 1, "R7 one pulse", seq_cnt - sbase, 1);

        // R8: valid held while not ready
        rx_ready = 1'b0;
        base = rx_cnt;
        sel_begin(1'b0);
        sbyte(8'h4B, g);
        #(4*H);
        chk(rx_valid == 1'b1 && rx_data == 8'h4B && rx_kind == 2'd0, "R8 hold valid",
            {rx_valid, rx_data}, {1'b1, 8'h4B});
        sel_end();
        chk(rx_valid == 1'b1 && rx_cnt == base, "R8 still waiting", rx_valid, 1);
        rx_ready = 1'b1;
        #(2*H);
        chk(rx_valid == 1'b0 && rx_cnt == base + 1, "R8 taken", rx_cnt - base, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule